// File: doc/BRIEF.md
# Return Address Stack Sequencer

This block keeps subroutine and interrupt return addresses for a small 8-bit controller core. It does not own any storage array. The stack lives in a shared byte-wide data RAM, and each nesting level uses a pair of bytes. The block also holds the 8-bit status word. The low three bits of that word are the stack pointer. Bit 4 picks which working-register bank the core addresses.

On a call or interrupt strobe, the block snapshots the program counter and the upper status nibble. It writes them into the pair chosen by the pointer, over two cycles, and then advances the pointer. On a return strobe, it steps the pointer back at once and reads the pair over the next two cycles. In the third cycle it presents the recovered program counter with a one-cycle done pulse. The restoring return variant also writes the saved nibble back into the status word. This brings back the register bank and the user flags that were live at the call.

A sequencer built around six named states controls all of this:
- `ST_IDLE`: accepts strobes and status writes.
  - It goes to `ST_PUSH_LO` on a call or interrupt.
  - It goes to `ST_POP_LO` on either return.
- `ST_PUSH_LO` goes to `ST_PUSH_HI` and then back to `ST_IDLE`.
- `ST_POP_LO` goes to `ST_POP_HI`, then to `ST_POP_FIN`, then back to `ST_IDLE`.

Top module: `rstk_top`

## Requirements
- R1: After reset the status word is 0x00, `busy` and `pc_done` are low, `bank_base` is 0, and there is no RAM access until a strobe arrives.
- R2: A push writes PC[7:0] to address 8+2n in the first cycle after the strobe edge. In the second cycle it writes {status[7:4], 2'b00, PC[9:8]} to address 9+2n. Here n is the pointer value when the strobe is taken, and the status nibble is the one held at that edge.
- R3: A push increments the pointer (status bits 2:0) when the second write completes. From 7 it wraps silently to 0, and the next push overwrites the pair at addresses 8 and 9.
- R4: A return decrements the pointer on the strobe edge, wrapping from 0 to 7. It reads address 8+2n and then 9+2n, where n is the new value. Three cycles after the strobe edge, `pc_done` is high for exactly one cycle, with `pc_out` = {hi[1:0], lo}.
- R5: The restoring return (`retr_req`) copies bits 7:4 of the high byte into status bits 7:4 and leaves bits 3:0 untouched. The plain return (`ret_req`) leaves status bits 7:4 unchanged.
- R6: `bank_base` is 0 when status bit 4 is 0 and 24 when it is 1. A restoring return therefore also brings back the bank.
- R7: While `busy` is high, every strobe is ignored. The pointer does not change and no extra RAM access occurs.
- R8: When several strobes arrive in the same cycle, the priority is interrupt, then call, then restoring return, then plain return. Interrupt and call store identical data.
- R9: A status write (`psw_wr`) replaces the whole status word, pointer included, but only in `ST_IDLE` with no strobe in the same cycle. Otherwise the write is dropped.
- R10: `ram_we` and `ram_re` are never high together, and every access lies in addresses 8 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Subroutine call strobe |
| irq_req | input | 1 | Interrupt entry strobe |
| ret_req | input | 1 | Plain return strobe |
| retr_req | input | 1 | Return-and-restore strobe |
| pc_in | input | 10 | Program counter to save |
| psw_wr | input | 1 | Status word write enable |
| psw_wdata | input | 8 | Status word write value |
| psw_q | output | 8 | Current status word (bits 2:0 are the pointer) |
| bank_base | output | 8 | RAM base of the selected register bank |
| pc_out | output | 10 | Recovered program counter |
| pc_done | output | 1 | One-cycle pulse when `pc_out` is fresh |
| busy | output | 1 | Sequencer is not in `ST_IDLE` |
| ram_addr | output | 8 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read enable (data returns next cycle) |
| ram_rdata | input | 8 | RAM read data |

## Verification
The assertions check several properties on every cycle:
- Write and read never overlap, and every address stays inside the stack window.
- The pointer moves only by +1 after the second push write and by −1 on a return strobe.
- The pointer stays still in the other busy states.
- A plain return keeps the status nibble, and `pc_done` never lasts two cycles.

Some behaviours can only be shown by the bench's scenarios, which compare against a reference model:
- The byte contents and pair placement.
- Wrap-around overwrite.
- Nibble and bank restoration.
- Strobe priority.
- Dropped status writes.
- The recovered PC values.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_FIN
    } rstk_state_e;

    // Arbitrated request kind
    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_IRQ,
        REQ_CALL,
        REQ_RETR,
        REQ_RET
    } rstk_req_e;

    function automatic logic req_is_push(input rstk_req_e r);
        return (r == REQ_IRQ) || (r == REQ_CALL);
    endfunction

    function automatic logic req_is_pop(input rstk_req_e r);
        return (r == REQ_RETR) || (r == REQ_RET);
    endfunction

endpackage

// File: rtl/rstk_arbiter.sv
module rstk_arbiter
    import rstk_pkg::*;
(
    input  logic      irq_req,
    input  logic      call_req,
    input  logic      retr_req,
    input  logic      ret_req,
    output rstk_req_e req
);

    // Fixed priority: interrupt, call, restoring return, plain return
    always_comb begin
        if (irq_req)       req = REQ_IRQ;
        else if (call_req) req = REQ_CALL;
        else if (retr_req) req = REQ_RETR;
        else if (ret_req)  req = REQ_RET;
        else               req = REQ_NONE;
    end

endmodule

// File: rtl/rstk_seq.sv
module rstk_seq
    import rstk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rstk_req_e   req,
    output rstk_state_e state_q,
    output logic        restore_q,
    output logic        busy,
    output logic        accept_sw,
    output logic        lat_en,
    output logic        sp_up,
    output logic        sp_dn,
    output logic        nib_ld,
    output logic        ram_we,
    output logic        ram_re,
    output logic        hi_sel,
    output logic        lo_cap,
    output logic        fin
);

    rstk_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Return flavour, latched when a return is taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            restore_q <= 1'b0;
        else if (state_q == ST_IDLE && req_is_pop(req))
            restore_q <= (req == REQ_RETR);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_is_push(req))     state_d = ST_PUSH_LO;
                else if (req_is_pop(req)) state_d = ST_POP_LO;
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_IDLE;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_POP_FIN;
            ST_POP_FIN: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy      = 1'b1;
        accept_sw = 1'b0;
        lat_en    = 1'b0;
        sp_up     = 1'b0;
        sp_dn     = 1'b0;
        nib_ld    = 1'b0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        hi_sel    = 1'b0;
        lo_cap    = 1'b0;
        fin       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                accept_sw = (req == REQ_NONE);
                lat_en    = req_is_push(req);
                sp_dn     = req_is_pop(req);
            end
            ST_PUSH_LO: begin
                ram_we = 1'b1;
            end
            ST_PUSH_HI: begin
                ram_we = 1'b1;
                hi_sel = 1'b1;
                sp_up  = 1'b1;
            end
            ST_POP_LO: begin
                ram_re = 1'b1;
            end
            ST_POP_HI: begin
                ram_re = 1'b1;
                hi_sel = 1'b1;
                lo_cap = 1'b1;
            end
            ST_POP_FIN: begin
                fin    = 1'b1;
                nib_ld = restore_q;
            end
            default: busy = 1'b1;
        endcase
    end

    // R7: the sequencer never leaves an active state toward another start
    p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_PUSH_LO && state_q != ST_POP_LO)
            || ($past(state_q) == ST_PUSH_HI) || ($past(state_q) == ST_POP_FIN));

endmodule

// File: rtl/rstk_psw.sv
module rstk_psw #(
    parameter int SP_W       = 3,
    parameter int ADDR_W     = 8,
    parameter int BANK0_BASE = 0,
    parameter int BANK1_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [7:0]        sw_data,
    input  logic              sp_up,
    input  logic              sp_dn,
    input  logic              nib_ld,
    input  logic [3:0]        nib_val,
    output logic [7:0]        psw_q,
    output logic [ADDR_W-1:0] bank_base
);

    localparam int BANK_BIT = 4;

    logic [SP_W-1:0] sp_cur;
    assign sp_cur = psw_q[SP_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= '0;
        end else if (sw_wr) begin
            psw_q <= sw_data;
        end else begin
            if (sp_up) psw_q[SP_W-1:0] <= sp_cur + 1'b1;
            if (sp_dn) psw_q[SP_W-1:0] <= sp_cur - 1'b1;
            if (nib_ld) psw_q[7:4] <= nib_val;
        end
    end

    assign bank_base = psw_q[BANK_BIT] ? ADDR_W'(BANK1_BASE) : ADDR_W'(BANK0_BASE);

    // R1: status word is clear in the first cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (psw_q == 8'h00));

endmodule

// File: rtl/rstk_bytes.sv
module rstk_bytes #(
    parameter int PC_W       = 10,
    parameter int SP_W       = 3,
    parameter int ADDR_W     = 8,
    parameter int STACK_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_en,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [3:0]        nib_in,
    input  logic [SP_W-1:0]   sp,
    input  logic              hi_sel,
    input  logic              lo_cap,
    input  logic              fin,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_done,
    output logic [3:0]        nib_rd
);

    localparam int HI_PC = PC_W - 8;
    localparam int PAD   = 8 - 4 - HI_PC;

    logic [PC_W-1:0] pc_l;
    logic [3:0]      nib_l;
    logic [7:0]      lo_l;
    logic [7:0]      hi_byte;

    // Snapshot of the values to push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_l  <= '0;
            nib_l <= '0;
        end else if (lat_en) begin
            pc_l  <= pc_in;
            nib_l <= nib_in;
        end
    end

    // Pair address: base + 2*pointer + byte select
    assign ram_addr = ADDR_W'(STACK_BASE)
                    + {{(ADDR_W-SP_W-1){1'b0}}, sp, hi_sel};

    generate
        if (PAD > 0) begin : g_pad
            assign hi_byte = {nib_l, {PAD{1'b0}}, pc_l[PC_W-1:8]};
            logic unused_pad;
            assign unused_pad = ^ram_rdata[3:HI_PC];
        end else begin : g_nopad
            assign hi_byte = {nib_l, pc_l[PC_W-1:8]};
        end
    endgenerate

    assign ram_wdata = hi_sel ? hi_byte : pc_l[7:0];
    assign nib_rd    = ram_rdata[7:4];

    // Read capture and PC reassembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_l    <= '0;
            pc_out  <= '0;
            pc_done <= 1'b0;
        end else begin
            pc_done <= fin;
            if (lo_cap) lo_l   <= ram_rdata;
            if (fin)    pc_out <= {ram_rdata[HI_PC-1:0], lo_l};
        end
    end

    // R4: the done pulse lasts exactly one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_done |=> !pc_done);

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int PC_W       = 10,
    parameter int SP_W       = 3,
    parameter int ADDR_W     = 8,
    parameter int STACK_BASE = 8,
    parameter int BANK1_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              irq_req,
    input  logic              ret_req,
    input  logic              retr_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              psw_wr,
    input  logic [7:0]        psw_wdata,
    output logic [7:0]        psw_q,
    output logic [ADDR_W-1:0] bank_base,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_done,
    output logic              busy,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic              ram_re,
    input  logic [7:0]        ram_rdata
);

    localparam int DEPTH    = 1 << SP_W;
    localparam int STACK_HI = STACK_BASE + 2 * DEPTH - 1;

    rstk_req_e   req;
    rstk_state_e state_q;
    logic restore_q, accept_sw, lat_en, sp_up, sp_dn, nib_ld;
    logic hi_sel, lo_cap, fin;
    logic [3:0] nib_rd;

    rstk_arbiter u_arb (
        .irq_req  (irq_req),
        .call_req (call_req),
        .retr_req (retr_req),
        .ret_req  (ret_req),
        .req      (req)
    );

    rstk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .state_q   (state_q),
        .restore_q (restore_q),
        .busy      (busy),
        .accept_sw (accept_sw),
        .lat_en    (lat_en),
        .sp_up     (sp_up),
        .sp_dn     (sp_dn),
        .nib_ld    (nib_ld),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .hi_sel    (hi_sel),
        .lo_cap    (lo_cap),
        .fin       (fin)
    );

    rstk_psw #(
        .SP_W       (SP_W),
        .ADDR_W     (ADDR_W),
        .BANK0_BASE (0),
        .BANK1_BASE (BANK1_BASE)
    ) u_psw (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (psw_wr && accept_sw),
        .sw_data   (psw_wdata),
        .sp_up     (sp_up),
        .sp_dn     (sp_dn),
        .nib_ld    (nib_ld),
        .nib_val   (nib_rd),
        .psw_q     (psw_q),
        .bank_base (bank_base)
    );

    rstk_bytes #(
        .PC_W       (PC_W),
        .SP_W       (SP_W),
        .ADDR_W     (ADDR_W),
        .STACK_BASE (STACK_BASE)
    ) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_en    (lat_en),
        .pc_in     (pc_in),
        .nib_in    (psw_q[7:4]),
        .sp        (psw_q[SP_W-1:0]),
        .hi_sel    (hi_sel),
        .lo_cap    (lo_cap),
        .fin       (fin),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .pc_out    (pc_out),
        .pc_done   (pc_done),
        .nib_rd    (nib_rd)
    );

    // R10: port exclusivity and address window
    p_no_we_re_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    p_addr_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr >= ADDR_W'(STACK_BASE)
                             && ram_addr <= ADDR_W'(STACK_HI)));

    // R3: the second push write is followed by a pointer increment
    p_push_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[0])
            |=> psw_q[SP_W-1:0] == SP_W'($past(psw_q[SP_W-1:0]) + 1'b1));

    // R4: a taken return steps the pointer back
    p_ret_decr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !irq_req && !call_req && (ret_req || retr_req))
            |=> psw_q[SP_W-1:0] == SP_W'($past(psw_q[SP_W-1:0]) - 1'b1));

    // R5: a plain return keeps the status nibble
    p_plain_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POP_FIN && !restore_q) |=> $stable(psw_q[7:4]));

    // R7: pointer frozen in the busy states that do not move it
    p_busy_sp_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_LO || state_q == ST_POP_LO
         || state_q == ST_POP_HI || state_q == ST_POP_FIN)
            |=> $stable(psw_q[SP_W-1:0]));

endmodule

// File: tb/rstk_top_tb_top.sv
module rstk_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic call_req = 0, irq_req = 0, ret_req = 0, retr_req = 0;
    logic [9:0] pc_in = '0;
    logic psw_wr = 0;
    logic [7:0] psw_wdata = '0;
    logic [7:0] psw_q, bank_base, ram_addr, ram_wdata;
    logic [7:0] ram_rdata = '0;
    logic [9:0] pc_out;
    logic pc_done, busy, ram_we, ram_re;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int bad_port = 0;

    logic [7:0] mem [0:255];
    logic [7:0] exp_psw = '0;
    logic [9:0] exp_pc [0:7];
    logic [3:0] exp_nib [0:7];

    always #10 clk = ~clk;

    rstk_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .irq_req(irq_req),
        .ret_req(ret_req), .retr_req(retr_req),
        .pc_in(pc_in), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .psw_q(psw_q), .bank_base(bank_base),
        .pc_out(pc_out), .pc_done(pc_done), .busy(busy),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // RAM model with one-cycle read latency, plus port monitor for R10
    always @(posedge clk) begin
        if (rst_n) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            if (ram_re) begin
                ram_rdata <= mem[ram_addr];
                reads <= reads + 1;
            end
            if ((ram_we && ram_re) ||
                ((ram_we || ram_re) && (ram_addr < 8'd8 || ram_addr > 8'd23)))
                bad_port <= bad_port + 1;
        end
    end

    function automatic logic [7:0] hi_of(input logic [3:0] nib, input logic [9:0] pc);
        return {nib, 2'b00, pc[9:8]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Push: strobe sampled at e0, two writes, pointer moves at e2
    task automatic op_push(input bit use_irq, input logic [9:0] pc);
        int n;
        n = int'(exp_psw[2:0]);
        @(negedge clk);
        irq_req = use_irq; call_req = !use_irq; pc_in = pc;
        @(negedge clk);
        irq_req = 0; call_req = 0;
        @(negedge clk);
        @(negedge clk);
        exp_pc[n] = pc;
        exp_nib[n] = exp_psw[7:4];
        exp_psw[2:0] = exp_psw[2:0] + 3'd1;
        check("R2 lo byte", mem[8+2*n], pc[7:0]);
        check("R2 hi byte", mem[9+2*n], hi_of(exp_nib[n], pc));
        check("R3 status after push", psw_q, exp_psw);
    endtask

    // Return: pointer moves at e0, done visible after e3
    task automatic op_pop(input bit restore);
        int n;
        @(negedge clk);
        retr_req = restore; ret_req = !restore;
        @(negedge clk);
        retr_req = 0; ret_req = 0;
        exp_psw[2:0] = exp_psw[2:0] - 3'd1;
        n = int'(exp_psw[2:0]);
        check("R4 pointer on strobe", psw_q, exp_psw);
        @(negedge clk);
        @(negedge clk);
        check("R4 no early done", pc_done, 0);
        @(negedge clk);
        check("R4 done pulse", pc_done, 1);
        check("R4 pc_out", pc_out, exp_pc[n]);
        if (restore) exp_psw[7:4] = exp_nib[n];
        check("R5 status after return", psw_q, exp_psw);
    endtask

    task automatic op_sw(input logic [7:0] d);
        @(negedge clk);
        psw_wr = 1; psw_wdata = d;
        @(negedge clk);
        psw_wr = 0;
        exp_psw = d;
        check("R9 status write", psw_q, exp_psw);
        check("R6 bank base", bank_base, d[4] ? 8'd24 : 8'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int r0;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) begin exp_pc[i] = '0; exp_nib[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 status reset", psw_q, 8'h00);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", pc_done, 0);
        check("R1 bank reset", bank_base, 0);
        check("R1 no reads", reads, 0);

        // R2/R3 basic push, then R6 bank switch
        op_push(0, 10'h2A5);
        op_sw(8'h11);
        op_push(1, 10'h13C);
        // R5 restoring return brings nibble (bank 1) back
        op_sw(8'h02);
        check("R6 bank cleared", bank_base, 0);
        op_pop(1);
        check("R6 bank restored", bank_base, 8'd24);
        // R5 plain return keeps nibble
        op_sw({4'hA, exp_psw[3:0]});
        op_pop(0);
        check("R5 plain keeps nibble", psw_q[7:4], 4'hA);

        // R3 wrap 7 -> 0 overwriting deepest pair
        op_sw(8'h07);
        op_push(0, 10'h3FF);
        check("R3 wrapped to 0", psw_q[2:0], 0);
        op_push(1, 10'h0F0);
        // R4 underflow 0 -> 7 after two pops
        op_pop(0);
        op_pop(0);
        check("R4 underflow to 7", psw_q[2:0], 3'd7);

        // R7 return strobe during a push is ignored
        begin
            int rd0, n;
            rd0 = reads;
            n = int'(exp_psw[2:0]);
            @(negedge clk); call_req = 1; pc_in = 10'h155;
            @(negedge clk); call_req = 0; ret_req = 1;
            @(negedge clk); ret_req = 0;
            @(negedge clk);
            exp_pc[n] = 10'h155; exp_nib[n] = exp_psw[7:4];
            exp_psw[2:0] = exp_psw[2:0] + 3'd1;
            check("R7 pointer only pushed", psw_q, exp_psw);
            check("R7 no reads", reads, rd0);
            check("R7 busy cleared", busy, 0);
        end

        // R8 priority: all four strobes together -> push
        begin
            int n;
            n = int'(exp_psw[2:0]);
            @(negedge clk);
            irq_req = 1; call_req = 1; ret_req = 1; retr_req = 1; pc_in = 10'h26B;
            @(negedge clk);
            irq_req = 0; call_req = 0; ret_req = 0; retr_req = 0;
            @(negedge clk); @(negedge clk);
            exp_pc[n] = 10'h26B; exp_nib[n] = exp_psw[7:4];
            exp_psw[2:0] = exp_psw[2:0] + 3'd1;
            check("R8 push wins", psw_q, exp_psw);
            check("R8 pushed lo", mem[8+2*n], 8'h6B);
        end
        // R8 restoring return beats plain return
        begin
            int n;
            op_sw({4'h0, exp_psw[3:0]});
            @(negedge clk); ret_req = 1; retr_req = 1;
            @(negedge clk); ret_req = 0; retr_req = 0;
            exp_psw[2:0] = exp_psw[2:0] - 3'd1;
            n = int'(exp_psw[2:0]);
            repeat (3) @(negedge clk);
            exp_psw[7:4] = exp_nib[n];
            check("R8 restore wins", psw_q, exp_psw);
        end

        // R9 status write with a strobe in the same cycle is dropped
        begin
            int n;
            n = int'(exp_psw[2:0]);
            @(negedge clk);
            psw_wr = 1; psw_wdata = 8'hFF; call_req = 1; pc_in = 10'h0AA;
            @(negedge clk); psw_wr = 0; call_req = 0;
            @(negedge clk); @(negedge clk);
            exp_pc[n] = 10'h0AA; exp_nib[n] = exp_psw[7:4];
            exp_psw[2:0] = exp_psw[2:0] + 3'd1;
            check("R9 write dropped with strobe", psw_q, exp_psw);
            // write during busy dropped
            @(negedge clk); ret_req = 1;
            @(negedge clk); ret_req = 0; psw_wr = 1; psw_wdata = 8'hC3;
            @(negedge clk); psw_wr = 0;
            @(negedge clk); @(negedge clk);
            exp_psw[2:0] = exp_psw[2:0] - 3'd1;
            check("R9 write dropped while busy", psw_q, exp_psw);
            check("R4 pc after busy write", pc_out, exp_pc[int'(exp_psw[2:0])]);
        end

        // Random mix
        for (int k = 0; k < 300; k++) begin
            r0 = int'($urandom % 8);
            case (r0)
                0, 1, 2: op_push(r0[0], 10'($urandom));
                3, 4:    op_pop(0);
                5:       op_pop(1);
                6:       op_sw(8'($urandom));
                default: op_push(1, 10'($urandom));
            endcase
        end

        check("R10 port discipline", bad_port, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule